// File: doc/BRIEF.md
# Upper-memory shadow RAM decoder

This block decides, for every access in the upper 256 KB of the first megabyte (C0000h to FFFFFh), whether the cycle is served by on-board DRAM or passed on to the external expansion bus. It treats reads and writes separately, which makes the usual ROM-shadowing sequence possible. Firmware first enables DRAM writes while reads still come from the ROM on the bus and copies the image. It then enables DRAM reads and disables DRAM writes, so the shadow copy is read-only.

The region has two granularities. The lower half (C0000h to DFFFFh) is split into eight 16 KB segments, each enabled by one bit of a segment byte. The upper half (E0000h to FFFFFh) is split into four 32 KB segments, enabled by the low bits of a control word. The two remaining control bits pick the read route and the write route for every enabled segment at once. Both configuration words are held in registers that load on the clock. The routing outputs are combinational from those registers and from the address.

The address enters as the 16 KB block number, which is bits 19..14 of the 20-bit physical address. Finer address bits play no part in the decision.

Top module: `umem_shadow_dec`

## Requirements
- R1: After reset both configuration registers are zero, so every access goes to the external bus and both BIOS shadow status outputs are 0.
- R2: `in_window` is 1 only when block address bits [5:4] are 2'b11 (C0000h and up). Outside the window, `rd_dram` and `wr_dram` are 0 for any configuration.
- R3: For blocks with bit [3] = 0, segment byte bit i (i = block bits [2:0]) enables the 16 KB segment at C0000h + i×4000h.
- R4: For blocks with bit [3] = 1, control word bit j (j = block bits [2:1], j = 0..3) enables the 32 KB segment at E0000h + j×8000h.
- R5: A read of an enabled segment asserts `rd_dram` exactly when control bit 4 is set. `rd_dram` is never asserted on a write.
- R6: A write to an enabled segment asserts `wr_dram` exactly when control bit 5 is set. `wr_dram` is never asserted on a read.
- R7: An access to a segment whose enable bit is clear keeps `rd_dram` and `wr_dram` at 0, whatever the routing bits hold.
- R8: `bios_rd_shadow` and `bios_wr_shadow` equal the registered control bits 4 and 5.
- R9: A configuration word is taken only on a rising clock edge with its load strobe high. Without the strobe, the stored value and the outputs derived from it hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_seg_we | input | 1 | Load strobe for the segment byte |
| cfg_seg_d | input | 8 | Enables for the eight 16 KB segments |
| cfg_ctl_we | input | 1 | Load strobe for the control word |
| cfg_ctl_d | input | 6 | Bits 3..0 enable the 32 KB segments; bit 4 selects DRAM reads, bit 5 selects DRAM writes |
| blk_addr | input | 6 | Physical address bits 19..14 |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| in_window | output | 1 | Access lies in C0000h..FFFFFh |
| rd_dram | output | 1 | Read is served from internal DRAM |
| wr_dram | output | 1 | Write goes to internal DRAM |
| bios_rd_shadow | output | 1 | BIOS shadow read status |
| bios_wr_shadow | output | 1 | BIOS shadow write status |

## Verification
The assertions assume that `is_write` is a known 0 or 1 in every sampled cycle. They also assume that the load strobes are low during reset, so the first post-reset comparison against the previous cycle's data sees a reset value. The bench drives every input from a defined value at time zero and keeps both strobes low until reset is released. It changes configuration only through a load task that raises the strobes for exactly one clock edge.

// File: rtl/umem_shadow_dec.sv
module umem_shadow_dec #(
  parameter int LO_SEGS = 8,
  parameter int HI_SEGS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_seg_we,
  input  logic [LO_SEGS-1:0]   cfg_seg_d,
  input  logic                 cfg_ctl_we,
  input  logic [HI_SEGS+1:0]   cfg_ctl_d,
  input  logic [5:0]           blk_addr,
  input  logic                 is_write,
  output logic                 in_window,
  output logic                 rd_dram,
  output logic                 wr_dram,
  output logic                 bios_rd_shadow,
  output logic                 bios_wr_shadow
);
  localparam int LO_BITS = $clog2(LO_SEGS);
  localparam int HI_BITS = $clog2(HI_SEGS);

  logic [LO_SEGS-1:0] lo_en_q;
  logic [HI_SEGS-1:0] hi_en_q;
  logic               rd_sel_q, wr_sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_en_q  <= '0;
      hi_en_q  <= '0;
      rd_sel_q <= 1'b0;
      wr_sel_q <= 1'b0;
    end else begin
      if (cfg_seg_we) lo_en_q <= cfg_seg_d;
      if (cfg_ctl_we) begin
        hi_en_q  <= cfg_ctl_d[HI_SEGS-1:0];
        rd_sel_q <= cfg_ctl_d[HI_SEGS];
        wr_sel_q <= cfg_ctl_d[HI_SEGS+1];
      end
    end
  end

  logic [LO_BITS-1:0] lo_idx;
  logic [HI_BITS-1:0] hi_idx;
  logic               upper_half, seg_on, shadowed;

  assign in_window  = &blk_addr[5:4];
  assign upper_half = blk_addr[3];
  assign lo_idx     = blk_addr[2:0];
  assign hi_idx     = blk_addr[2:1];
  assign seg_on     = upper_half ? hi_en_q[hi_idx] : lo_en_q[lo_idx];
  assign shadowed   = in_window & seg_on;

  assign rd_dram        = shadowed & ~is_write & rd_sel_q;
  assign wr_dram        = shadowed &  is_write & wr_sel_q;
  assign bios_rd_shadow = rd_sel_q;
  assign bios_wr_shadow = wr_sel_q;
endmodule

// File: rtl/umem_shadow_dec_chk.sv
module umem_shadow_dec_chk #(
  parameter int LO_SEGS = 8,
  parameter int HI_SEGS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_seg_we,
  input logic [LO_SEGS-1:0] cfg_seg_d,
  input logic               cfg_ctl_we,
  input logic [HI_SEGS+1:0] cfg_ctl_d,
  input logic [5:0]         blk_addr,
  input logic               is_write,
  input logic               in_window,
  input logic               rd_dram,
  input logic               wr_dram,
  input logic               bios_rd_shadow,
  input logic               bios_wr_shadow
);
  // R2
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> (!rd_dram && !wr_dram));
  // R5
  rd_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dram |-> (!is_write && bios_rd_shadow && in_window));
  // R6
  wr_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dram |-> (is_write && bios_wr_shadow && in_window));
  // R8
  status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ctl_we |=> (bios_rd_shadow == $past(cfg_ctl_d[HI_SEGS])
                    && bios_wr_shadow == $past(cfg_ctl_d[HI_SEGS+1])));
  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ctl_we |=> ($stable(bios_rd_shadow) && $stable(bios_wr_shadow)));
  // R5
  exclusive_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_dram && wr_dram));
endmodule

bind umem_shadow_dec umem_shadow_dec_chk #(.LO_SEGS(LO_SEGS), .HI_SEGS(HI_SEGS)) u_chk (.*);

// File: tb/umem_shadow_dec_bench.sv
module umem_shadow_dec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_seg_we = 1'b0, cfg_ctl_we = 1'b0, is_write = 1'b0;
  logic [7:0] cfg_seg_d = '0;
  logic [5:0] cfg_ctl_d = '0;
  logic [5:0] blk_addr = '0;
  logic in_window, rd_dram, wr_dram, bios_rd_shadow, bios_wr_shadow;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  umem_shadow_dec u_umem_shadow_dec (
    .clk(clk), .rst_n(rst_n), .cfg_seg_we(cfg_seg_we), .cfg_seg_d(cfg_seg_d),
    .cfg_ctl_we(cfg_ctl_we), .cfg_ctl_d(cfg_ctl_d), .blk_addr(blk_addr),
    .is_write(is_write), .in_window(in_window), .rd_dram(rd_dram),
    .wr_dram(wr_dram), .bios_rd_shadow(bios_rd_shadow), .bios_wr_shadow(bios_wr_shadow));

  // {seg, ctl(6), addr(20), write, exp_in, exp_rd, exp_wr}
  localparam int NV = 16;
  localparam logic [37:0] VEC [NV] = '{
    {8'h01, 6'h10, 20'hC0000, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 R5
    {8'h01, 6'h10, 20'hC3FFF, 1'b0, 1'b1, 1'b1, 1'b0},  // R3
    {8'h01, 6'h10, 20'hC4000, 1'b0, 1'b1, 1'b0, 1'b0},  // R7
    {8'h80, 6'h20, 20'hDC000, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 R6
    {8'h80, 6'h20, 20'hDFFFF, 1'b0, 1'b1, 1'b0, 1'b0},  // R5
    {8'h00, 6'h31, 20'hE0000, 1'b0, 1'b1, 1'b1, 1'b0},  // R4
    {8'h00, 6'h31, 20'hE7FFF, 1'b1, 1'b1, 1'b0, 1'b1},  // R4 R6
    {8'h00, 6'h31, 20'hE8000, 1'b0, 1'b1, 1'b0, 1'b0},  // R7
    {8'h00, 6'h38, 20'hF8000, 1'b1, 1'b1, 1'b0, 1'b1},  // R4
    {8'h00, 6'h38, 20'hFFFFF, 1'b0, 1'b1, 1'b1, 1'b0},  // R4
    {8'hFF, 6'h30, 20'hBFFFF, 1'b0, 1'b0, 1'b0, 1'b0},  // R2
    {8'hFF, 6'h30, 20'h00000, 1'b1, 1'b0, 1'b0, 1'b0},  // R2
    {8'hFF, 6'h0F, 20'hE0000, 1'b0, 1'b1, 1'b0, 1'b0},  // R5
    {8'hFF, 6'h0F, 20'hD0000, 1'b1, 1'b1, 1'b0, 1'b0},  // R6
    {8'h10, 6'h30, 20'hD0000, 1'b1, 1'b1, 1'b0, 1'b1},  // R3
    {8'h10, 6'h30, 20'hCC000, 1'b0, 1'b1, 1'b0, 1'b0}   // R7
  };

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load_cfg(logic [7:0] s, logic [5:0] c);
    @(negedge clk);
    cfg_seg_d = s; cfg_ctl_d = c; cfg_seg_we = 1'b1; cfg_ctl_we = 1'b1;
    @(negedge clk);
    cfg_seg_we = 1'b0; cfg_ctl_we = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    blk_addr = 6'h38;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 rd_dram", rd_dram, 1'b0);
    check("R1 bios_rd_shadow", bios_rd_shadow, 1'b0);
    check("R1 bios_wr_shadow", bios_wr_shadow, 1'b0);
    is_write = 1'b1; #1;
    check("R1 wr_dram", wr_dram, 1'b0);

    for (int i = 0; i < NV; i++) begin
      load_cfg(VEC[i][37:30], VEC[i][29:24]);
      blk_addr = VEC[i][23:18];
      is_write = VEC[i][3];
      #1;
      check("R2 in_window", in_window, VEC[i][2]);
      check("R3/R4/R5/R7 rd_dram", rd_dram, VEC[i][1]);
      check("R3/R4/R6/R7 wr_dram", wr_dram, VEC[i][0]);
      check("R8 bios_rd_shadow", bios_rd_shadow, VEC[i][28]);
      check("R8 bios_wr_shadow", bios_wr_shadow, VEC[i][29]);
    end

    // R9: strobes low, data changes are ignored
    load_cfg(8'h01, 6'h30);
    blk_addr = 6'h30; is_write = 1'b0;
    cfg_seg_d = 8'h00; cfg_ctl_d = 6'h00;
    @(negedge clk); #1;
    check("R9 rd_dram held", rd_dram, 1'b1);
    check("R9 bios_wr_shadow held", bios_wr_shadow, 1'b1);
    // R9: strobe high but before the edge, old value stays
    @(negedge clk);
    cfg_ctl_we = 1'b1; #1;
    check("R9 before edge", bios_rd_shadow, 1'b1);
    @(negedge clk);
    cfg_ctl_we = 1'b0; #1;
    check("R9 after edge", bios_rd_shadow, 1'b0);
    check("R9 rd_dram after load", rd_dram, 1'b0);

    // R1 again: reset clears loaded configuration
    load_cfg(8'hFF, 6'h3F);
    rst_n = 1'b0; #1;
    check("R1 reset clears rd_dram", rd_dram, 1'b0);
    check("R1 reset clears bios_wr_shadow", bios_wr_shadow, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule